// File: doc/BRIEF.md
# Read-Path Bandwidth Monitor

This block watches the address-request and read-data handshakes of one read path. It gathers raw counts over a measurement window that software controls, and software turns those counts into peak bandwidth, sustained throughput, data-channel utilization and efficiency. It keeps busy-beat bytes, the bytes a full-width beat would have carried, and the byte lanes left empty by narrow bursts in separate counters, so that the cause of a shortfall can be read directly. Lane waste, address overhead and too little latency cover each show up in their own counter.

The monitor is passive. The address channel (`ar_valid`/`ar_ready` with `ar_len` and `ar_size`) and the data channel (`r_valid`/`r_ready` with `r_last`) are observation inputs only. The monitor never drives a ready and never applies back-pressure. A transfer on either channel counts only in a cycle where both valid and ready are high. A cycle with valid high and ready low is a stall and counts as idle. Bursts are assumed to return in order under a single ID. Each accepted burst's size code goes into a 16-entry in-order queue, so every data beat is charged at the size of the burst it belongs to. Software divides the counts: for example, efficiency is useful bytes over peak bytes, and average depth is the depth sum over window cycles.

Top module: `rdbw_monitor`

## Requirements
- R1: A one-cycle `win_start` pulse sets every counter to zero and opens the window. Counting begins in the cycle after the pulse. A `win_stop` pulse closes the window and is itself not counted. `win_start` wins when both pulses arrive together. While the window is closed, every counter holds its value.
- R2: In each window cycle, `cyc_cnt` grows by one. `busy_cnt` grows by one when `r_valid` and `r_ready` are both high, and `idle_cnt` grows by one otherwise.
- R3: `peak_bytes` grows by `DATA_BYTES` on every window cycle.
- R4: On each window cycle with an address handshake, `xact_bytes` grows by (`ar_len`+1) shifted left by `ar_size`, and `addr_cnt` grows by one.
- R5: On each data beat, `useful_bytes` grows by 2^size of the oldest burst whose last beat has not yet been seen. The value is capped at `DATA_BYTES`, and `waste_bytes` grows by `DATA_BYTES` minus that amount. A beat that arrives with no burst queued counts as full width.
- R6: `depth` rises by one on each address handshake and falls by one on each data handshake with `r_last`. It stays unchanged when both happen in one cycle and never goes below zero. It follows the traffic whether or not the window is open.
- R7: On each window cycle, `depth_sum` grows by the value `depth` holds at the start of that cycle.
- R8: Every counter saturates at all ones (2^`CNT_W`-1) and does not wrap.
- R9: `err_flag` is set by a data handshake with `r_last` while `depth` is zero. It is also set by an address handshake while 16 bursts are queued and none leaves in that cycle, and the size of that excess burst is dropped. Once set, the flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_start | input | 1 | Pulse: clear counters, open window |
| win_stop | input | 1 | Pulse: close window |
| ar_valid | input | 1 | Observed address valid |
| ar_ready | input | 1 | Observed address ready |
| ar_len | input | LEN_W | Observed burst length minus one |
| ar_size | input | SIZE_W | Observed log2 bytes per beat |
| r_valid | input | 1 | Observed read-data valid |
| r_ready | input | 1 | Observed read-data ready |
| r_last | input | 1 | Observed last beat of burst |
| win_open | output | 1 | Window is open |
| cyc_cnt | output | CNT_W | Window cycles |
| busy_cnt | output | CNT_W | Cycles with a data beat |
| idle_cnt | output | CNT_W | Cycles without a data beat |
| peak_bytes | output | CNT_W | Full-width capacity in bytes |
| xact_bytes | output | CNT_W | Bytes requested by bursts |
| useful_bytes | output | CNT_W | Bytes carried by beats |
| waste_bytes | output | CNT_W | Empty lanes of narrow beats |
| addr_cnt | output | CNT_W | Address handshakes |
| depth_sum | output | CNT_W | Sum of outstanding depth per cycle |
| depth | output | DEPTH_W | Current outstanding bursts |
| err_flag | output | 1 | Sticky protocol/overflow error |

## Verification
The bench sweeps every size code, including one above the bus width, against several burst lengths and data-channel stall patterns. A design that charged beats at full width, or failed to cap an oversize code, would show wrong useful and waste totals. It overlaps bursts of different sizes and puts an address handshake and a last beat in the same cycle. A design that popped the size queue too early, or moved the depth in that cycle, would drift from the expected depth sum. It fires the start and stop pulses together and restarts while the window is open, and it runs a long idle window so that peak bytes saturate. A design that wrapped, or that let stop override start, would show up in those cases. The last tests drive a last beat with nothing outstanding and a seventeenth burst into a full queue, and check that the error flag stays set.

// File: rtl/rdbw_pkg.sv
package rdbw_pkg;
  typedef enum int unsigned {
    C_CYC   = 0,
    C_BUSY  = 1,
    C_IDLE  = 2,
    C_PEAK  = 3,
    C_XACT  = 4,
    C_USE   = 5,
    C_WASTE = 6,
    C_ADDR  = 7,
    C_DSUM  = 8
  } cnt_idx_e;

  localparam int unsigned N_CNT = 9;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/rdbw_sat_cnt.sv
module rdbw_sat_cnt #(
  parameter int unsigned CNT_W = 48,
  parameter int unsigned INC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);
  localparam int unsigned SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;
  localparam logic [SUM_W-1:0] TOP = SUM_W'({CNT_W{1'b1}});

  logic [SUM_W-1:0] sum;

  always_comb sum = SUM_W'(cnt) + SUM_W'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= (sum > TOP) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
  end

  AST_SAT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && en) |=> (cnt >= $past(cnt))); // R8
  AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(cnt)); // R1
endmodule

// File: rtl/rdbw_size_fifo.sv
module rdbw_size_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         ovf
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          full, do_pop, do_push;

  always_comb begin
    empty   = (count == '0);
    full    = (count == CW'(DEPTH));
    do_pop  = pop && !empty;
    do_push = push && (!full || do_pop);
    ovf     = push && full && !do_pop;
    dout    = mem[rptr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always @(posedge clk) begin
    if (rst_n) AST_FIFO_BOUND: assert (count <= CW'(DEPTH)); // R9
  end
endmodule

// File: rtl/rdbw_depth_track.sv
module rdbw_depth_track #(
  parameter int unsigned DEPTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up,
  input  logic               down,
  output logic [DEPTH_W-1:0] depth,
  output logic               underflow
);
  localparam logic [DEPTH_W-1:0] DMAX = {DEPTH_W{1'b1}};

  always_comb underflow = down && (depth == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) depth <= '0;
    else if (up && !down && depth != DMAX) depth <= depth + 1'b1;
    else if (down && !up && depth != '0)   depth <= depth - 1'b1;
  end

  AST_DEPTH_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (up && down) |=> $stable(depth)); // R6
  AST_DEPTH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !down && depth != DMAX) |=> (depth == $past(depth) + 1'b1)); // R6
endmodule

// File: rtl/rdbw_monitor.sv
module rdbw_monitor
  import rdbw_pkg::*;
#(
  parameter int unsigned DATA_BYTES = 16,
  parameter int unsigned CNT_W      = 48,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned SIZE_W     = 3,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned DEPTH_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               win_start,
  input  logic               win_stop,
  input  logic               ar_valid,
  input  logic               ar_ready,
  input  logic [LEN_W-1:0]   ar_len,
  input  logic [SIZE_W-1:0]  ar_size,
  input  logic               r_valid,
  input  logic               r_ready,
  input  logic               r_last,
  output logic               win_open,
  output logic [CNT_W-1:0]   cyc_cnt,
  output logic [CNT_W-1:0]   busy_cnt,
  output logic [CNT_W-1:0]   idle_cnt,
  output logic [CNT_W-1:0]   peak_bytes,
  output logic [CNT_W-1:0]   xact_bytes,
  output logic [CNT_W-1:0]   useful_bytes,
  output logic [CNT_W-1:0]   waste_bytes,
  output logic [CNT_W-1:0]   addr_cnt,
  output logic [CNT_W-1:0]   depth_sum,
  output logic [DEPTH_W-1:0] depth,
  output logic               err_flag
);
  localparam int unsigned FULL_SIZE = $clog2(DATA_BYTES);
  localparam int unsigned BB_W      = LEN_W + 1 + (1 << SIZE_W) - 1;
  localparam int unsigned DB_W      = FULL_SIZE + 1;
  localparam int unsigned INC_W     = max3(BB_W, DB_W, DEPTH_W);

  logic ar_hs, r_hs, last_hs, count_en;
  logic head_empty, q_ovf, d_under;
  logic [SIZE_W-1:0] head_size;
  logic [INC_W-1:0]  burst_bytes, beat_use;
  logic [N_CNT-1:0][INC_W-1:0] inc_vec;
  logic [N_CNT-1:0][CNT_W-1:0] cnt_vec;

  always_comb begin
    ar_hs    = ar_valid && ar_ready;
    r_hs     = r_valid && r_ready;
    last_hs  = r_hs && r_last;
    count_en = win_open && !win_start && !win_stop;
    burst_bytes = (INC_W'(ar_len) + INC_W'(1)) << ar_size;
    if (head_empty || int'(head_size) >= int'(FULL_SIZE)) beat_use = INC_W'(DATA_BYTES);
    else                                                   beat_use = INC_W'(1) << head_size;
  end

  always_comb begin
    inc_vec          = '0;
    inc_vec[C_CYC]   = INC_W'(1);
    inc_vec[C_BUSY]  = INC_W'(r_hs);
    inc_vec[C_IDLE]  = INC_W'(!r_hs);
    inc_vec[C_PEAK]  = INC_W'(DATA_BYTES);
    inc_vec[C_XACT]  = ar_hs ? burst_bytes : '0;
    inc_vec[C_USE]   = r_hs ? beat_use : '0;
    inc_vec[C_WASTE] = r_hs ? (INC_W'(DATA_BYTES) - beat_use) : '0;
    inc_vec[C_ADDR]  = INC_W'(ar_hs);
    inc_vec[C_DSUM]  = INC_W'(depth);
  end

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    rdbw_sat_cnt #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(win_start), .en(count_en),
      .inc(inc_vec[g]), .cnt(cnt_vec[g])
    );
  end

  rdbw_size_fifo #(.DEPTH(FIFO_DEPTH), .W(SIZE_W)) u_sizes (
    .clk(clk), .rst_n(rst_n), .push(ar_hs), .din(ar_size), .pop(last_hs),
    .dout(head_size), .empty(head_empty), .ovf(q_ovf)
  );

  rdbw_depth_track #(.DEPTH_W(DEPTH_W)) u_depth (
    .clk(clk), .rst_n(rst_n), .up(ar_hs), .down(last_hs),
    .depth(depth), .underflow(d_under)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_open <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (win_start)     win_open <= 1'b1;
      else if (win_stop) win_open <= 1'b0;
      if (q_ovf || d_under) err_flag <= 1'b1;
    end
  end

  always_comb begin
    cyc_cnt      = cnt_vec[C_CYC];
    busy_cnt     = cnt_vec[C_BUSY];
    idle_cnt     = cnt_vec[C_IDLE];
    peak_bytes   = cnt_vec[C_PEAK];
    xact_bytes   = cnt_vec[C_XACT];
    useful_bytes = cnt_vec[C_USE];
    waste_bytes  = cnt_vec[C_WASTE];
    addr_cnt     = cnt_vec[C_ADDR];
    depth_sum    = cnt_vec[C_DSUM];
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |=> (win_open && cyc_cnt == '0 && useful_bytes == '0)); // R1
  AST_STOP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (win_stop && !win_start) |=> !win_open); // R1
endmodule

// File: tb/rdbw_monitor_bench.sv
module rdbw_monitor_bench;
  localparam int PERIOD = 10;
  localparam int DB     = 4;
  localparam int CW     = 10;
  localparam int QD     = 16;
  localparam longint CMAX = (64'd1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic win_start = 0, win_stop = 0, ar_valid = 0, ar_ready = 0;
  logic [7:0] ar_len = 0;
  logic [2:0] ar_size = 0;
  logic r_valid = 0, r_ready = 0, r_last = 0;
  logic win_open, err_flag;
  logic [CW-1:0] cyc_cnt, busy_cnt, idle_cnt, peak_bytes, xact_bytes;
  logic [CW-1:0] useful_bytes, waste_bytes, addr_cnt, depth_sum;
  logic [7:0] depth;

  int n_chk = 0, n_bad = 0;
  longint m [9];
  int  mdepth;
  bit  mopen, merr;
  int  q[$];

  always #(PERIOD/2) clk = ~clk;

  rdbw_monitor #(.DATA_BYTES(DB), .CNT_W(CW), .LEN_W(8), .SIZE_W(3),
                 .FIFO_DEPTH(QD), .DEPTH_W(8)) u_rdbw_monitor (
    .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_stop(win_stop),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_len(ar_len), .ar_size(ar_size),
    .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last),
    .win_open(win_open), .cyc_cnt(cyc_cnt), .busy_cnt(busy_cnt), .idle_cnt(idle_cnt),
    .peak_bytes(peak_bytes), .xact_bytes(xact_bytes), .useful_bytes(useful_bytes),
    .waste_bytes(waste_bytes), .addr_cnt(addr_cnt), .depth_sum(depth_sum),
    .depth(depth), .err_flag(err_flag)
  );

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 win_open", win_open, mopen);
    chk("R2 cyc_cnt", cyc_cnt, m[0]);
    chk("R2 busy_cnt", busy_cnt, m[1]);
    chk("R2 idle_cnt", idle_cnt, m[2]);
    chk("R3 R8 peak_bytes", peak_bytes, m[3]);
    chk("R4 xact_bytes", xact_bytes, m[4]);
    chk("R5 useful_bytes", useful_bytes, m[5]);
    chk("R5 waste_bytes", waste_bytes, m[6]);
    chk("R4 addr_cnt", addr_cnt, m[7]);
    chk("R7 depth_sum", depth_sum, m[8]);
    chk("R6 depth", depth, mdepth);
    chk("R9 err_flag", err_flag, merr);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; win_start = 0; win_stop = 0; ar_valid = 0; ar_ready = 0;
    r_valid = 0; r_ready = 0; r_last = 0;
    foreach (m[i]) m[i] = 0;
    mdepth = 0; mopen = 0; merr = 0; q.delete();
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1 compare_all();
  endtask

  task automatic tick(bit st, bit sp, bit arv, bit arr, int len, int sz,
                      bit rv, bit rr, bit rl);
    bit arhs, beat, lhs;
    longint u;
    longint incs [9];
    @(negedge clk);
    win_start = st; win_stop = sp; ar_valid = arv; ar_ready = arr;
    ar_len = 8'(len); ar_size = 3'(sz); r_valid = rv; r_ready = rr; r_last = rl;
    arhs = arv && arr; beat = rv && rr; lhs = beat && rl;
    u = (q.size() > 0) ? (((64'd1 << q[0]) < DB) ? (64'd1 << q[0]) : DB) : DB;
    incs[0] = 1; incs[1] = beat; incs[2] = !beat; incs[3] = DB;
    incs[4] = arhs ? (longint'(len + 1) << sz) : 0;
    incs[5] = beat ? u : 0; incs[6] = beat ? DB - u : 0;
    incs[7] = arhs; incs[8] = mdepth;
    if (st) begin
      foreach (m[i]) m[i] = 0;
      mopen = 1;
    end else if (sp) mopen = 0;
    else if (mopen) foreach (m[i]) m[i] = (m[i] + incs[i] > CMAX) ? CMAX : m[i] + incs[i];
    if (lhs && mdepth == 0) merr = 1;
    if (arhs && !lhs && mdepth < 255) mdepth++;
    else if (lhs && !arhs && mdepth > 0) mdepth--;
    if (lhs && q.size() > 0) void'(q.pop_front());
    if (arhs) begin
      if (q.size() < QD) q.push_back(sz);
      else merr = 1;
    end
    @(posedge clk);
    #1 compare_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lens [4] = '{0, 1, 2, 5};
    do_reset();                      // reset state, all requirements
    idle(3);                         // R1 closed window holds zero

    // R2 R4 R5 R6 R7: sweep every size code (3 exceeds the 4-byte bus) and lengths
    for (int sz = 0; sz < 4; sz++) begin
      for (int li = 0; li < 4; li++) begin
        tick(1, 0, 0, 0, 0, 0, 0, 0, 0);
        tick(0, 0, 1, 0, lens[li], sz, 0, 0, 0);   // address stall
        tick(0, 0, 1, 1, lens[li], sz, 0, 0, 0);   // address handshake
        for (int k = 0; k <= lens[li]; k++) begin
          if (((k + sz) % 2) == 1) tick(0, 0, 0, 0, 0, 0, 1, 0, k == lens[li]);
          tick(0, 0, 0, 0, 0, 0, 1, 1, k == lens[li]);
        end
        tick(0, 1, 0, 0, 0, 0, 0, 0, 0);
        idle(2);                                   // R1 hold after stop
      end
    end

    // R5 R6: overlapped bursts, address and last beat in the same cycle
    tick(1, 0, 0, 0, 0, 0, 0, 0, 0);
    tick(0, 0, 1, 1, 1, 0, 0, 0, 0);
    tick(0, 0, 1, 1, 1, 1, 0, 0, 0);
    tick(0, 0, 1, 1, 0, 2, 1, 1, 0);
    tick(0, 0, 1, 1, 0, 3, 1, 1, 1);               // R6 both handshakes
    tick(0, 0, 0, 0, 0, 0, 1, 1, 0);
    tick(0, 0, 0, 0, 0, 0, 1, 1, 1);
    tick(0, 0, 0, 0, 0, 0, 1, 1, 1);
    tick(0, 0, 0, 0, 0, 0, 1, 0, 1);
    tick(0, 0, 0, 0, 0, 0, 1, 1, 1);
    // R1 restart while open, then start and stop together
    tick(1, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(2);
    tick(1, 1, 0, 0, 0, 0, 0, 0, 0);
    idle(2);
    tick(0, 1, 0, 0, 0, 0, 0, 0, 0);

    // R8: long window saturates the peak counter
    tick(1, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(300);
    tick(0, 1, 0, 0, 0, 0, 0, 0, 0);

    // R9: last beat with nothing outstanding
    tick(1, 0, 0, 0, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0, 1, 1, 1);
    idle(2);
    do_reset();

    // R9: seventeenth burst into a full size queue, then drain
    tick(1, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 17; i++) tick(0, 0, 1, 1, 0, i % 3, 0, 0, 0);
    for (int i = 0; i < 17; i++) tick(0, 0, 0, 0, 0, 0, 1, 1, 1);
    idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule